// File: doc/BRIEF.md
# Infrared Link Descriptor Ring Walker

This block sequences the DMA descriptor rings of a serial infrared link controller. One 1 KB aligned base address in memory holds two rings of 8-byte slots. The receive ring starts at the base and the transmit ring starts 0x200 bytes above it. For each ring the block keeps a current-slot pointer. It reads the slot at that pointer over a simple request/acknowledge memory port. If the hardware-owns flag is set, it hands the slot's buffer address, length and control byte to the link data path. When the data path reports completion, it writes the slot's first word back with status and the owns flag cleared, then steps the pointer.

Software places the base address in three byte registers and picks each ring's size with a nibble code. It wakes the walker by writing bit 0 of a prompt register. Both rings then re-read the slot at their pointers and keep walking until they meet a slot the hardware does not own. Completion events leave the block as single-cycle pulses.

Top module: `ir_ring_walker`

## Requirements
- R1: Base address bits 17..10, 25..18 and 31..26 are written through byte registers at offsets 0x2, 0x3 and 0x4 (the last holds 6 bits in bits 5..0, bits 7..6 read 0). Base bits 9..0 are always zero, and all three registers read back and reset to 0.
- R2: The size register at offset 0x5 (reset 0) holds the receive code in bits 3..0 and the transmit code in bits 7..4. Codes 0x0, 0x1, 0x3, 0x7 and 0xF give rings of 4, 8, 16, 32 and 64 slots.
- R3: A slot is two 32-bit words at base + 8*pointer (receive) or base + 0x200 + 8*pointer (transmit). Word 0 carries the length in bits 11..0 (bits 15..12 spare), a spare byte in bits 23..16 and the control byte in bits 31..24. Word 1, at +4, is the buffer address.
- R4: A slot whose control bit 7 (owns) is clear is read but never written. The walker stops there with the pointer unchanged and raises no event.
- R5: Writing a byte with bit 0 set to offset 0x6 makes both rings re-read the slot at their pointers. A write with bit 0 clear causes no memory request. Offset 0x6 reads 0.
- R6: Receive write-back puts the data path's 6-bit status into control bits 6..1 and clears bits 7 and 0. It puts the received 12-bit length into bits 11..0, zeroes bits 15..12 and keeps the spare byte. It leaves word 1 untouched and pulses rx_done_evt for one cycle after the write is acknowledged.
- R7: Transmit write-back clears control bit 7, sets control bit 0 to the data path's underrun flag, and keeps control bits 6..1, the length and the spare byte. tx_done_evt pulses once after the write is acknowledged, only when control bit 2 of that slot was set.
- R8: The receive and transmit pointers read at offsets 0x0 and 0x1 as 6-bit values (bits 7..6 zero, reset 0). Writes there are ignored. A pointer moves only at the write-back acknowledge, to (pointer + 1) modulo the ring size.
- R9: mem_req, mem_wr, mem_addr and mem_wdata stay stable from the request until mem_ack, with at most one access outstanding.
- R10: While a slot is presented (rx_slot_vld / tx_slot_vld), its buffer address, length and control byte are those fetched from the slot and stay stable until the matching fin input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete (read data valid) |
| mem_rdata | input | 32 | Read data |
| rx_slot_vld | output | 1 | Receive slot handed to data path |
| rx_slot_buf | output | 32 | Receive buffer address |
| rx_slot_len | output | 12 | Receive slot length field |
| rx_slot_ctl | output | 8 | Receive slot control byte as fetched |
| rx_fin | input | 1 | Receive slot finished |
| rx_fin_len | input | 12 | Received frame length |
| rx_fin_stat | input | 6 | Receive status for control bits 6..1 |
| rx_done_evt | output | 1 | Receive slot completion pulse |
| tx_slot_vld | output | 1 | Transmit slot handed to data path |
| tx_slot_buf | output | 32 | Transmit buffer address |
| tx_slot_len | output | 12 | Transmit length |
| tx_slot_ctl | output | 8 | Transmit control byte as fetched |
| tx_fin | input | 1 | Transmit slot finished |
| tx_fin_under | input | 1 | Transmit underrun flag |
| tx_done_evt | output | 1 | Transmit completion pulse |

## Verification
Register reads are combinational, so a register written at one edge is sampled half a cycle after that edge. A prompt takes two edges to reach the rings, and the first memory request appears one edge after that, through the arbiter. The bench therefore waits for the rings to go quiet before checking pointers and memory. Each completion pulse and pointer step falls in the cycle right after the acknowledge of the write-back. The bench counts pulses at every falling edge and compares totals once the walk settles. It compares the slot fields presented to the data path at the falling edge where the valid flag is first seen. Memory latency and data path delay are drawn at random, so every result is checked against when it is due relative to a handshake, not against a fixed count.

// File: rtl/ir_ring_pkg.sv
`timescale 1ns/1ps
package ir_ring_pkg;
   localparam int PTR_W      = 6;
   localparam int LEN_W      = 12;
   localparam int WORD_W     = 32;
   localparam int STAT_W     = 7;
   localparam int NCH        = 2;
   localparam int BASE_LSB   = 10;
   localparam int BASE_BITS  = 32 - BASE_LSB;

   localparam logic [2:0] REG_RX_PTR   = 3'd0;
   localparam logic [2:0] REG_TX_PTR   = 3'd1;
   localparam logic [2:0] REG_BASE_LO  = 3'd2;
   localparam logic [2:0] REG_BASE_MID = 3'd3;
   localparam logic [2:0] REG_BASE_HI  = 3'd4;
   localparam logic [2:0] REG_SIZE     = 3'd5;
   localparam logic [2:0] REG_PROMPT   = 3'd6;

   localparam int OWN_BIT    = 31;
   localparam int DONE_REQ   = 26;

   typedef enum logic [2:0] {
      CH_IDLE,
      CH_HEAD,
      CH_ADDR,
      CH_RUN,
      CH_WBACK
   } chan_st_e;
endpackage

// File: rtl/ir_ring_cfg.sv
`timescale 1ns/1ps
module ir_ring_cfg
   import ir_ring_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic [2:0]               addr,
   input  logic [7:0]               wdata,
   output logic [7:0]               rdata,
   input  logic [PTR_W-1:0]         rx_ptr,
   input  logic [PTR_W-1:0]         tx_ptr,
   output logic [ADDR_W-11:0]       base,
   output logic [PTR_W-1:0]         rx_mask,
   output logic [PTR_W-1:0]         tx_mask,
   output logic                     prompt
);
   localparam int HI_W = BASE_BITS - 16;

   logic [BASE_BITS-1:0] base_q;
   logic [7:0]           size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         size_q <= '0;
         prompt <= 1'b0;
      end else begin
         prompt <= wr && (addr == REG_PROMPT) && wdata[0];
         if (wr) begin
            case (addr)
               REG_BASE_LO:  base_q[7:0]   <= wdata;
               REG_BASE_MID: base_q[15:8]  <= wdata;
               REG_BASE_HI:  base_q[BASE_BITS-1:16] <= wdata[HI_W-1:0];
               REG_SIZE:     size_q        <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (addr)
         REG_RX_PTR:   rdata = {{(8-PTR_W){1'b0}}, rx_ptr};
         REG_TX_PTR:   rdata = {{(8-PTR_W){1'b0}}, tx_ptr};
         REG_BASE_LO:  rdata = base_q[7:0];
         REG_BASE_MID: rdata = base_q[15:8];
         REG_BASE_HI:  rdata = {{(8-HI_W){1'b0}}, base_q[BASE_BITS-1:16]};
         REG_SIZE:     rdata = size_q;
         default:      rdata = 8'h00;
      endcase
   end

   // ring size code is a thermometer; the pointer mask is that code above two ones
   assign rx_mask = {size_q[3:0], 2'b11};
   assign tx_mask = {size_q[7:4], 2'b11};
   assign base    = base_q[ADDR_W-11:0];
endmodule

// File: rtl/ir_ring_chan.sv
`timescale 1ns/1ps
module ir_ring_chan
   import ir_ring_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter bit IS_TX  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-11:0]   base,
   input  logic [PTR_W-1:0]     mask,
   input  logic                 prompt,
   output logic                 req,
   output logic                 wr,
   output logic [ADDR_W-1:0]    addr,
   output logic [WORD_W-1:0]    wdata,
   input  logic                 ack,
   input  logic [WORD_W-1:0]    rdata,
   output logic [PTR_W-1:0]     ptr,
   output logic                 slot_vld,
   output logic [WORD_W-1:0]    slot_buf,
   output logic [LEN_W-1:0]     slot_len,
   output logic [7:0]           slot_ctl,
   input  logic                 fin,
   input  logic [LEN_W-1:0]     fin_len,
   input  logic [STAT_W-1:0]    fin_stat,
   output logic                 done_evt
);
   if (ADDR_W < 11 || ADDR_W > 32) begin : g_bad_aw
      $error("ir_ring_chan: ADDR_W must lie in 11..32");
   end

   chan_st_e          st;
   logic              pend;
   logic [WORD_W-1:0] w0;
   logic [WORD_W-1:0] buf_q;
   logic [LEN_W-1:0]  fin_len_q;
   logic [STAT_W-1:0] fin_stat_q;
   logic [PTR_W-1:0]  ptr_next;
   logic              done_want;
   logic [15:0]       len_field;
   logic [7:0]        ctl_field;

   assign ptr_next = (ptr + PTR_W'(1)) & mask;

   // transmit keeps its fields and reports underrun; receive reports status and length
   assign len_field = IS_TX ? w0[15:0] : {{(16-LEN_W){1'b0}}, fin_len_q};
   assign ctl_field = IS_TX ? {1'b0, w0[30:25], fin_stat_q[0]}
                            : {1'b0, fin_stat_q[6:1], 1'b0};
   assign done_want = IS_TX ? w0[DONE_REQ] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= CH_IDLE;
         pend       <= 1'b0;
         ptr        <= '0;
         w0         <= '0;
         buf_q      <= '0;
         fin_len_q  <= '0;
         fin_stat_q <= '0;
         done_evt   <= 1'b0;
      end else begin
         done_evt <= 1'b0;
         if (prompt) pend <= 1'b1;
         case (st)
            CH_IDLE: begin
               if (pend || prompt) begin
                  st   <= CH_HEAD;
                  pend <= 1'b0;
               end
            end
            CH_HEAD: begin
               if (ack) begin
                  w0 <= rdata;
                  st <= rdata[OWN_BIT] ? CH_ADDR : CH_IDLE;
               end
            end
            CH_ADDR: begin
               if (ack) begin
                  buf_q <= rdata;
                  st    <= CH_RUN;
               end
            end
            CH_RUN: begin
               if (fin) begin
                  fin_len_q  <= fin_len;
                  fin_stat_q <= fin_stat;
                  st         <= CH_WBACK;
               end
            end
            CH_WBACK: begin
               if (ack) begin
                  ptr      <= ptr_next;
                  done_evt <= done_want;
                  st       <= CH_HEAD;
               end
            end
            default: st <= CH_IDLE;
         endcase
      end
   end

   assign req      = (st == CH_HEAD) || (st == CH_ADDR) || (st == CH_WBACK);
   assign wr       = (st == CH_WBACK);
   assign addr     = {base, IS_TX, ptr, (st == CH_ADDR), 2'b00};
   assign wdata    = {ctl_field, w0[23:16], len_field};
   assign slot_vld = (st == CH_RUN);
   assign slot_buf = buf_q;
   assign slot_len = w0[LEN_W-1:0];
   assign slot_ctl = w0[31:24];
endmodule

// File: rtl/ir_ring_arb.sv
`timescale 1ns/1ps
module ir_ring_arb #(
   parameter int N = 2,
   localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             mem_ack,
   output logic             mem_req,
   output logic [SEL_W-1:0] sel,
   output logic [N-1:0]     ack
);
   if (N < 1) begin : g_bad_n
      $error("ir_ring_arb: N must be at least 1");
   end

   logic             busy;
   logic [SEL_W-1:0] pick;

   // lowest index wins when several ask in the same cycle
   always_comb begin
      pick = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) pick = SEL_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sel  <= '0;
      end else if (!busy) begin
         if (|req) begin
            busy <= 1'b1;
            sel  <= pick;
         end
      end else if (mem_ack) begin
         busy <= 1'b0;
      end
   end

   assign mem_req = busy && req[sel];

   for (genvar g = 0; g < N; g++) begin : g_ack
      assign ack[g] = busy && mem_ack && (sel == SEL_W'(g));
   end
endmodule

// File: rtl/ir_ring_walker.sv
`timescale 1ns/1ps
module ir_ring_walker
   import ir_ring_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              mem_req,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              rx_slot_vld,
   output logic [31:0]       rx_slot_buf,
   output logic [11:0]       rx_slot_len,
   output logic [7:0]        rx_slot_ctl,
   input  logic              rx_fin,
   input  logic [11:0]       rx_fin_len,
   input  logic [5:0]        rx_fin_stat,
   output logic              rx_done_evt,
   output logic              tx_slot_vld,
   output logic [31:0]       tx_slot_buf,
   output logic [11:0]       tx_slot_len,
   output logic [7:0]        tx_slot_ctl,
   input  logic              tx_fin,
   input  logic              tx_fin_under,
   output logic              tx_done_evt
);
   localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

   if (ADDR_W < 11 || ADDR_W > 32) begin : g_bad_aw
      $error("ir_ring_walker: ADDR_W must lie in 11..32");
   end

   logic [ADDR_W-11:0] base;
   logic [PTR_W-1:0]   mask   [NCH];
   logic [PTR_W-1:0]   ptr    [NCH];
   logic               prompt;

   logic [NCH-1:0]     ch_req;
   logic [NCH-1:0]     ch_ack;
   logic               ch_wr    [NCH];
   logic [ADDR_W-1:0]  ch_addr  [NCH];
   logic [WORD_W-1:0]  ch_wdata [NCH];
   logic               ch_vld   [NCH];
   logic [WORD_W-1:0]  ch_buf   [NCH];
   logic [LEN_W-1:0]   ch_len   [NCH];
   logic [7:0]         ch_ctl   [NCH];
   logic               ch_fin   [NCH];
   logic [LEN_W-1:0]   ch_flen  [NCH];
   logic [STAT_W-1:0]  ch_fstat [NCH];
   logic               ch_evt   [NCH];
   logic [SEL_W-1:0]   sel;
   logic [PTR_W-1:0]   rx_ptr;
   logic [PTR_W-1:0]   tx_ptr;

   ir_ring_cfg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .rx_ptr  (rx_ptr),
      .tx_ptr  (tx_ptr),
      .base    (base),
      .rx_mask (mask[0]),
      .tx_mask (mask[1]),
      .prompt  (prompt)
   );

   // channel 0 walks the receive ring, channel 1 the transmit ring
   assign ch_fin[0]   = rx_fin;
   assign ch_flen[0]  = rx_fin_len;
   assign ch_fstat[0] = {rx_fin_stat, 1'b0};
   assign ch_fin[1]   = tx_fin;
   assign ch_flen[1]  = '0;
   assign ch_fstat[1] = {{(STAT_W-1){1'b0}}, tx_fin_under};

   for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
      ir_ring_chan #(.ADDR_W(ADDR_W), .IS_TX(gi == 1)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .base     (base),
         .mask     (mask[gi]),
         .prompt   (prompt),
         .req      (ch_req[gi]),
         .wr       (ch_wr[gi]),
         .addr     (ch_addr[gi]),
         .wdata    (ch_wdata[gi]),
         .ack      (ch_ack[gi]),
         .rdata    (mem_rdata),
         .ptr      (ptr[gi]),
         .slot_vld (ch_vld[gi]),
         .slot_buf (ch_buf[gi]),
         .slot_len (ch_len[gi]),
         .slot_ctl (ch_ctl[gi]),
         .fin      (ch_fin[gi]),
         .fin_len  (ch_flen[gi]),
         .fin_stat (ch_fstat[gi]),
         .done_evt (ch_evt[gi])
      );
   end

   ir_ring_arb #(.N(NCH)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (ch_req),
      .mem_ack (mem_ack),
      .mem_req (mem_req),
      .sel     (sel),
      .ack     (ch_ack)
   );

   assign mem_wr    = ch_wr[sel];
   assign mem_addr  = ch_addr[sel];
   assign mem_wdata = ch_wdata[sel];

   assign rx_ptr      = ptr[0];
   assign tx_ptr      = ptr[1];
   assign rx_slot_vld = ch_vld[0];
   assign rx_slot_buf = ch_buf[0];
   assign rx_slot_len = ch_len[0];
   assign rx_slot_ctl = ch_ctl[0];
   assign rx_done_evt = ch_evt[0];
   assign tx_slot_vld = ch_vld[1];
   assign tx_slot_buf = ch_buf[1];
   assign tx_slot_len = ch_len[1];
   assign tx_slot_ctl = ch_ctl[1];
   assign tx_done_evt = ch_evt[1];
endmodule

// File: rtl/ir_ring_walker_chk.sv
`timescale 1ns/1ps
module ir_ring_walker_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_wr,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              rx_done_evt,
   input logic              tx_done_evt,
   input logic [5:0]        rx_ptr,
   input logic [5:0]        tx_ptr,
   input logic              rx_slot_vld,
   input logic              rx_fin,
   input logic [31:0]       rx_slot_buf,
   input logic [11:0]       rx_slot_len
);
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wr)
                                 && $stable(mem_wdata)));

   assert_rx_evt_after_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_evt |-> $past(mem_ack && mem_wr && !mem_addr[9]));

   assert_tx_evt_after_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done_evt |-> $past(mem_ack && mem_wr && mem_addr[9]));

   assert_rx_ptr_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ptr != $past(rx_ptr)) |-> $past(mem_ack && mem_wr && !mem_addr[9]));

   assert_tx_ptr_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ptr != $past(tx_ptr)) |-> $past(mem_ack && mem_wr && mem_addr[9]));

   assert_slot_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_slot_vld && !rx_fin) |=> (rx_slot_vld && $stable(rx_slot_buf)
                                    && $stable(rx_slot_len)));
endmodule

bind ir_ring_walker ir_ring_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_req     (mem_req),
   .mem_wr      (mem_wr),
   .mem_ack     (mem_ack),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .rx_done_evt (rx_done_evt),
   .tx_done_evt (tx_done_evt),
   .rx_ptr      (rx_ptr),
   .tx_ptr      (tx_ptr),
   .rx_slot_vld (rx_slot_vld),
   .rx_fin      (rx_fin),
   .rx_slot_buf (rx_slot_buf),
   .rx_slot_len (rx_slot_len)
);

// File: tb/sim_ir_ring_walker.sv
`timescale 1ns/1ps
module sim_ir_ring_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        mem_req, mem_wr;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = 32'd0;
   logic        rx_slot_vld, tx_slot_vld;
   logic [31:0] rx_slot_buf, tx_slot_buf;
   logic [11:0] rx_slot_len, tx_slot_len;
   logic [7:0]  rx_slot_ctl, tx_slot_ctl;
   logic        rx_fin = 1'b0;
   logic [11:0] rx_fin_len = 12'd0;
   logic [5:0]  rx_fin_stat = 6'd0;
   logic        tx_fin = 1'b0;
   logic        tx_fin_under = 1'b0;
   logic        rx_done_evt, tx_done_evt;

   int errors = 0;
   int checks = 0;
   bit done_flag = 1'b0;

   logic [31:0] mem     [256];
   logic [31:0] exp_mem [256];
   logic [21:0] base22 = 22'd0;
   int rx_slots = 4, tx_slots = 4;
   int exp_rx_ptr = 0, exp_tx_ptr = 0;
   int rx_evt_cnt = 0, tx_evt_cnt = 0, exp_tx_evt = 0;
   int req_cnt = 0;

   always #2.5 clk = ~clk;

   ir_ring_walker u0 (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_check(input logic [2:0] a, input logic [7:0] e, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(reg_rdata == e, req, {24'd0, reg_rdata}, {24'd0, e});
   endtask

   // memory model: random latency, checks handshake stability (R9) and address (R3)
   initial begin
      logic [31:0] a_hold, d_hold;
      logic        w_hold;
      bit pend;
      int lat;
      pend = 1'b0; lat = 0; a_hold = '0; d_hold = '0; w_hold = 1'b0;
      forever begin
         @(negedge clk);
         if (mem_req) req_cnt++;
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req) begin
            if (!pend) begin
               pend = 1'b1; lat = int'($urandom % 3);
               a_hold = mem_addr; d_hold = mem_wdata; w_hold = mem_wr;
               chk(mem_addr[31:10] == base22 && mem_addr[1:0] == 2'b00, "R3",
                   mem_addr, {base22, mem_addr[9:2], 2'b00});
            end else begin
               chk(mem_addr == a_hold && mem_wdata == d_hold && mem_wr == w_hold,
                   "R9", mem_addr, a_hold);
            end
            if (lat == 0) begin
               if (mem_wr) mem[mem_addr[9:2]] = mem_wdata;
               else mem_rdata = mem[mem_addr[9:2]];
               mem_ack = 1'b1;
               pend = 1'b0;
            end else lat--;
         end
      end
   end

   // receive data path model
   initial begin
      int s, d;
      logic [11:0] ln;
      logic [5:0]  st;
      forever begin
         @(negedge clk);
         if (rx_slot_vld) begin
            s = exp_rx_ptr;
            chk(rx_slot_len == exp_mem[s*2][11:0], "R10", {20'd0, rx_slot_len},
                {20'd0, exp_mem[s*2][11:0]});
            chk(rx_slot_buf == exp_mem[s*2+1], "R10", rx_slot_buf, exp_mem[s*2+1]);
            d = int'($urandom % 3);
            repeat (d) @(negedge clk);
            ln = 12'($urandom); st = 6'($urandom);
            rx_fin = 1'b1; rx_fin_len = ln; rx_fin_stat = st;
            exp_mem[s*2] = {1'b0, st, 1'b0, exp_mem[s*2][23:16], 4'd0, ln};
            exp_rx_ptr = (s + 1) % rx_slots;
            @(negedge clk);
            rx_fin = 1'b0;
         end
      end
   end

   // transmit data path model
   initial begin
      int s, d;
      logic [7:0] ctl;
      logic un;
      forever begin
         @(negedge clk);
         if (tx_slot_vld) begin
            s = exp_tx_ptr;
            ctl = exp_mem[128+s*2][31:24];
            chk(tx_slot_ctl == ctl, "R10", {24'd0, tx_slot_ctl}, {24'd0, ctl});
            chk(tx_slot_len == exp_mem[128+s*2][11:0], "R10", {20'd0, tx_slot_len},
                {20'd0, exp_mem[128+s*2][11:0]});
            chk(tx_slot_buf == exp_mem[129+s*2], "R10", tx_slot_buf, exp_mem[129+s*2]);
            d = int'($urandom % 3);
            repeat (d) @(negedge clk);
            un = 1'($urandom);
            tx_fin = 1'b1; tx_fin_under = un;
            exp_mem[128+s*2] = {(ctl & 8'h7E) | {7'd0, un}, exp_mem[128+s*2][23:0]};
            if (ctl[2]) exp_tx_evt++;
            exp_tx_ptr = (s + 1) % tx_slots;
            @(negedge clk);
            tx_fin = 1'b0;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (rx_done_evt) rx_evt_cnt++;
         if (tx_done_evt) tx_evt_cnt++;
      end
   end

   task automatic init_ring(input bit tx, input int size, input int start, input int k);
      for (int s = 0; s < 64; s++) begin
         int i0;
         logic [31:0] w;
         i0 = (tx ? 128 : 0) + s * 2;
         w = $urandom;
         w[31] = (s < size) && (((s - start + size) % size) < k);
         mem[i0] = w; exp_mem[i0] = w;
         w = $urandom;
         mem[i0+1] = w; exp_mem[i0+1] = w;
      end
   endtask

   task automatic wait_quiet();
      int q, n;
      q = 0; n = 0;
      while (q < 40 && n < 20000) begin
         @(negedge clk);
         n++;
         if (mem_req || rx_slot_vld || tx_slot_vld) q = 0; else q++;
      end
      chk(n < 20000, "R4", n, 20000);
   endtask

   task automatic run_round(input int ci, input int rk_in, input int tk_in,
                            input bit pre_zero);
      int rk, tk, prx, ptx, rx0, tx0, tev0;
      logic [3:0] code;
      code = 4'((1 << ci) - 1);
      rx_slots = 4 << ci; tx_slots = 4 << ci;
      reg_write(3'd5, {code, code});
      reg_check(3'd5, {code, code}, "R2");
      rk = (rk_in < 0) ? int'($urandom % (rx_slots + 1)) : rk_in;
      tk = (tk_in < 0) ? int'($urandom % (tx_slots + 1)) : tk_in;
      prx = exp_rx_ptr; ptx = exp_tx_ptr;
      init_ring(1'b0, rx_slots, prx, rk);
      init_ring(1'b1, tx_slots, ptx, tk);
      rx0 = rx_evt_cnt; tx0 = tx_evt_cnt; tev0 = exp_tx_evt;
      if (pre_zero) begin
         req_cnt = 0;
         reg_write(3'd6, 8'hFE);
         repeat (30) @(negedge clk);
         chk(req_cnt == 0, "R5", req_cnt, 0);
         reg_check(3'd0, 8'(prx), "R5");
         reg_check(3'd6, 8'h00, "R5");
      end
      reg_write(3'd6, 8'h01);
      wait_quiet();
      reg_check(3'd0, 8'((prx + rk) % rx_slots), "R8");
      reg_check(3'd1, 8'((ptx + tk) % tx_slots), "R8");
      chk(rx_evt_cnt - rx0 == rk, "R6", rx_evt_cnt - rx0, rk);
      chk(tx_evt_cnt - tx0 == exp_tx_evt - tev0, "R7", tx_evt_cnt - tx0, exp_tx_evt - tev0);
      for (int i = 0; i < 256; i++) begin
         chk(mem[i] == exp_mem[i], (i < 128) ? "R6 R4" : "R7 R4", mem[i], exp_mem[i]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         errors++; checks++;
         $display("FAIL watchdog R4 actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) begin mem[i] = '0; exp_mem[i] = '0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      reg_check(3'd0, 8'h00, "R8");
      reg_check(3'd1, 8'h00, "R8");
      reg_check(3'd2, 8'h00, "R1");
      reg_check(3'd3, 8'h00, "R1");
      reg_check(3'd4, 8'h00, "R1");
      reg_check(3'd5, 8'h00, "R2");
      chk(!mem_req && !rx_slot_vld && !tx_slot_vld, "R9", {31'd0, mem_req}, 0);
      // base fields and readback
      reg_write(3'd2, 8'hA5);
      reg_write(3'd3, 8'h3C);
      reg_write(3'd4, 8'hFF);
      reg_check(3'd2, 8'hA5, "R1");
      reg_check(3'd3, 8'h3C, "R1");
      reg_check(3'd4, 8'h3F, "R1");
      reg_write(3'd0, 8'h15);
      reg_check(3'd0, 8'h00, "R8");
      base22 = 22'($urandom);
      reg_write(3'd2, base22[7:0]);
      reg_write(3'd3, base22[15:8]);
      reg_write(3'd4, {2'b00, base22[21:16]});
      // directed: full 4-slot receive ring wraps to 0, transmit stops after 3
      run_round(0, 4, 3, 1'b0);
      // directed: prompt with bit 0 clear does nothing; an unowned transmit slot stays
      run_round(1, 2, 0, 1'b1);
      // random rounds over growing ring sizes
      for (int ci = 1; ci < 5; ci++) begin
         run_round(ci, -1, -1, 1'b0);
         run_round(ci, -1, -1, 1'b0);
      end
      // directed: both 64-slot rings fully owned
      run_round(4, 64, 64, 1'b0);
      // directed: nothing owned anywhere
      run_round(4, 0, 0, 1'b0);
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule